// File: doc/BRIEF.md
# Digital Phase-Frequency Detector

This block compares the rising edges of a reference clock and a feedback clock, both sampled by one fast system clock. It drives `up` when the feedback edge trails the reference and `down` when it comes first, for a charge pump or a digital loop filter placed after it. It keeps flag state from one edge to the next, so the loop is pulled toward lock even while the two inputs run at different frequencies. It also reports each measured offset as a signed count of system clocks, and raises a lock flag once a run of small errors has been seen.

Two output modes are available. In proportional mode the outputs are the raw flags. The net pulse width tracks the error, and a zero offset still gives one short `up` and one short `down` pulse in the same cycle. In bang-bang mode each comparison yields either nothing, when the error is inside a programmable dead band, or a single pulse of fixed width whose only information is its sign.

Top module: `phase_freq_detector`

## Requirements
- R1: Each of `ref_in` and `fb_in` passes through two synchroniser flops and one edge-detect flop. In proportional mode, a rise on `ref_in` raises `up`, and a rise on `fb_in` raises `down`, at the third `clk` rising edge after the input change.
- R2: In proportional mode (`mode`=0), with the feedback edge k>0 clocks after the reference edge, `up` is high for k+1 cycles and `down` for 1 cycle, and the two overlap in exactly one cycle.
- R3: In proportional mode, with the feedback edge k>0 clocks before the reference edge, `down` is high for k+1 cycles and `up` for 1 cycle, with exactly one cycle of overlap.
- R4: In proportional mode, when both edges arrive in the same cycle, `up` and `down` are each high for exactly one cycle, and that cycle is the same for both.
- R5: Once both flags are set (the compare cycle), both clear on the next cycle, unless fresh edges arrive on both inputs in that same compare cycle.
- R6: One cycle after the compare cycle, `phase_err` holds +k if the feedback lagged by k clocks, -k if it led, and 0 for equal edges. The magnitude saturates at 2^(CNT_W-1)-1.
- R7: When the reference runs faster than the feedback, `up` is high for more cycles in total than `down`, and the reverse holds when the feedback runs faster.
- R8: In bang-bang mode (`mode`=1), a comparison whose error magnitude is at or below `deadband_width` produces neither `up` nor `down`.
- R9: In bang-bang mode, a comparison whose error magnitude is above `deadband_width` raises only `up` (feedback lagging) or only `down` (feedback leading), for exactly BB_PULSE cycles, whatever the size of the error.
- R10: `locked` rises together with the `phase_err` update of the LOCK_COUNT-th consecutive comparison with magnitude at or below `deadband_width`. Any comparison above it clears `locked` and restarts the run.
- R11: Synchronous `rst` drives `up`, `down`, `phase_err` and `locked` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_in | input | 1 | Reference clock, asynchronous |
| fb_in | input | 1 | Feedback clock, asynchronous |
| mode | input | 1 | 0 proportional, 1 bang-bang |
| deadband_width | input | DB_W | Dead band and lock threshold in system clocks |
| up | output | 1 | Speed-up request |
| down | output | 1 | Slow-down request |
| phase_err | output | CNT_W | Signed error of the last comparison, positive when feedback lags |
| locked | output | 1 | Lock indication |

## Verification
The embedded properties are checked on every cycle. They cover the following: each flag rise is traced back to a detected edge, both flags clear after a comparison, bang-bang mode never raises both outputs and stays silent inside the dead band, a positive error follows a lagging feedback, and an out-of-band comparison drops the lock. Other behaviours depend on whole input sequences and are only shown by the bench scenarios. These are the exact pulse widths in each mode, the three-cycle input latency, saturation of the error count, the sixteen-comparison lock run, and the net pull direction when the two clocks differ in frequency.

// File: rtl/phase_freq_detector.sv
module phase_freq_detector #(
  parameter int CNT_W      = 8,
  parameter int DB_W       = 4,
  parameter int LOCK_COUNT = 16,
  parameter int BB_PULSE   = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ref_in,
  input  logic                    fb_in,
  input  logic                    mode,
  input  logic [DB_W-1:0]         deadband_width,
  output logic                    up,
  output logic                    down,
  output logic signed [CNT_W-1:0] phase_err,
  output logic                    locked
);

  localparam int MAG_W = CNT_W - 1;
  localparam int CMP_W = (MAG_W > DB_W) ? MAG_W : DB_W;
  localparam int LCW   = $clog2(LOCK_COUNT + 1);
  localparam int BBW   = $clog2(BB_PULSE + 1);
  localparam logic [MAG_W-1:0] MAG_MAX = '1;

  logic [2:0]       ref_sh, fb_sh;
  logic             ref_rise, fb_rise;
  logic             up_q, dn_q, lead_up, cmp, in_band;
  logic [MAG_W-1:0] mag_q;
  logic [LCW-1:0]   lock_cnt;
  logic [BBW-1:0]   bb_len;
  logic             bb_up;
  logic signed [CNT_W-1:0] err_now;

  assign ref_rise = ref_sh[1] & ~ref_sh[2];
  assign fb_rise  = fb_sh[1] & ~fb_sh[2];
  assign cmp      = up_q & dn_q;
  assign in_band  = CMP_W'(mag_q) <= CMP_W'(deadband_width);
  assign err_now  = lead_up ? $signed({1'b0, mag_q}) : -$signed({1'b0, mag_q});
  assign locked   = lock_cnt == LCW'(LOCK_COUNT);
  assign up       = mode ? (bb_len != '0) &  bb_up : up_q;
  assign down     = mode ? (bb_len != '0) & ~bb_up : dn_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sh <= '0;
      fb_sh  <= '0;
    end else begin
      ref_sh <= {ref_sh[1:0], ref_in};
      fb_sh  <= {fb_sh[1:0], fb_in};
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      up_q    <= 1'b0;
      dn_q    <= 1'b0;
      lead_up <= 1'b0;
      mag_q   <= '0;
    end else begin
      up_q <= cmp ? ref_rise : (up_q | ref_rise);
      dn_q <= cmp ? fb_rise  : (dn_q | fb_rise);
      if (up_q ^ dn_q) begin
        lead_up <= up_q;
        if (mag_q != MAG_MAX) mag_q <= mag_q + 1'b1;
      end else begin
        mag_q <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_err <= '0;
      lock_cnt  <= '0;
      bb_len    <= '0;
      bb_up     <= 1'b0;
    end else begin
      if (cmp) begin
        phase_err <= err_now;
        if (!in_band)
          lock_cnt <= '0;
        else if (!locked)
          lock_cnt <= lock_cnt + 1'b1;
      end
      if (cmp && mode) begin
        bb_len <= in_band ? '0 : BBW'(BB_PULSE);
        bb_up  <= lead_up;
      end else if (bb_len != '0) begin
        bb_len <= bb_len - 1'b1;
      end
    end
  end

  AST_UP_FROM_EDGE: assert property (@(posedge clk) disable iff (rst)
    $rose(up_q) |-> $past(ref_rise)); // R1
  AST_PAIR_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (cmp && !(ref_rise && fb_rise)) |=> !(up_q && dn_q)); // R5
  AST_ERR_SIGN: assert property (@(posedge clk) disable iff (rst)
    (cmp && mag_q != '0 && lead_up) |=> (phase_err > 0)); // R6
  AST_BB_SILENT: assert property (@(posedge clk) disable iff (rst)
    (mode && cmp && in_band) |=> (!mode || (!up && !down))); // R8
  AST_BB_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
    mode |-> !(up && down)); // R9
  AST_LOCK_DROP: assert property (@(posedge clk) disable iff (rst)
    (cmp && !in_band) |=> !locked); // R10

endmodule

// File: tb/phase_freq_detector_tb.sv
module phase_freq_detector_tb_top;
  localparam int CNT_W = 8, DB_W = 4, LOCK_COUNT = 16, BB_PULSE = 2;
  localparam int MAGMAX = (1 << (CNT_W - 1)) - 1;

  logic clk = 0, rst = 1, ref_in = 0, fb_in = 0, mode = 0;
  logic [DB_W-1:0] deadband_width = '0;
  logic up, down, locked;
  logic signed [CNT_W-1:0] phase_err;

  int tot = 0, fail = 0, lc = 0;
  int ucnt = 0, dcnt = 0, bcnt = 0;
  bit meas = 0;

  always #5 clk = ~clk;

  phase_freq_detector #(.CNT_W(CNT_W), .DB_W(DB_W), .LOCK_COUNT(LOCK_COUNT), .BB_PULSE(BB_PULSE)) dut_i (
    .clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in), .mode(mode),
    .deadband_width(deadband_width), .up(up), .down(down),
    .phase_err(phase_err), .locked(locked));

  always @(negedge clk) if (meas) begin
    if (up) ucnt++;
    if (down) dcnt++;
    if (up && down) bcnt++;
  end

  task automatic chk(string req, int act, int exp);
    tot++;
    if (act != exp) begin
      fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int absi(int v); return v < 0 ? -v : v; endfunction
  function automatic int sat_mag(int k); return absi(k) > MAGMAX ? MAGMAX : absi(k); endfunction
  function automatic int exp_err(int k); return k < 0 ? -sat_mag(k) : sat_mag(k); endfunction

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    lc = 0;
    chk("R11 up", up, 0);
    chk("R11 down", down, 0);
    chk("R11 phase_err", phase_err, 0);
    chk("R11 locked", locked, 0);
    rst = 0;
    repeat (2) @(negedge clk);
  endtask

  // k > 0: feedback edge k clocks after reference edge
  task automatic pair(int k, bit m, int db);
    int mag;
    string tg;
    mode = m;
    deadband_width = DB_W'(db);
    @(negedge clk);
    ucnt = 0; dcnt = 0; bcnt = 0; meas = 1;
    if (k >= 0) begin
      ref_in = 1;
      repeat (k) @(negedge clk);
      fb_in = 1;
    end else begin
      fb_in = 1;
      repeat (-k) @(negedge clk);
      ref_in = 1;
    end
    repeat (8) @(negedge clk);
    ref_in = 0; fb_in = 0;
    repeat (5) @(negedge clk);
    meas = 0;
    mag = sat_mag(k);
    if (!m) begin
      tg = (k > 0) ? "R2" : (k < 0) ? "R3" : "R4";
      chk({tg, " up width"}, ucnt, (k >= 0) ? k + 1 : 1);
      chk({tg, " down width"}, dcnt, (k <= 0) ? -k + 1 : 1);
      chk({tg, " R5 overlap"}, bcnt, 1);
    end else if (mag <= db) begin
      chk("R8 up silent", ucnt, 0);
      chk("R8 down silent", dcnt, 0);
    end else begin
      chk("R9 up", ucnt, (k > 0) ? BB_PULSE : 0);
      chk("R9 down", dcnt, (k < 0) ? BB_PULSE : 0);
    end
    chk("R6 phase_err", int'(phase_err), exp_err(k));
    if (mag <= db) lc = (lc < LOCK_COUNT) ? lc + 1 : lc;
    else lc = 0;
    chk("R10 locked", locked, (lc >= LOCK_COUNT) ? 1 : 0);
  endtask

  task automatic latency(bit use_ref);
    int first = 0;
    mode = 0;
    @(negedge clk);
    if (use_ref) ref_in = 1; else fb_in = 1;
    for (int i = 1; i <= 6; i++) begin
      @(negedge clk);
      if (first == 0 && (use_ref ? up : down)) first = i;
    end
    if (use_ref) fb_in = 1; else ref_in = 1;
    repeat (8) @(negedge clk);
    ref_in = 0; fb_in = 0;
    repeat (5) @(negedge clk);
    chk(use_ref ? "R1 ref to up" : "R1 fb to down", first, 3);
    lc = 0;
  endtask

  task automatic freq_run(int pr, int pf, bit ref_fast);
    mode = 0;
    @(negedge clk);
    ucnt = 0; dcnt = 0; bcnt = 0; meas = 1;
    for (int t = 0; t < 300; t++) begin
      ref_in = (t % pr) < (pr / 2);
      fb_in  = (t % pf) < (pf / 2);
      @(negedge clk);
    end
    meas = 0;
    ref_in = 0; fb_in = 0;
    repeat (5) @(negedge clk);
    chk(ref_fast ? "R7 up dominates" : "R7 down dominates",
        ref_fast ? int'(ucnt > dcnt) : int'(dcnt > ucnt), 1);
    do_reset();
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", tot - fail, tot);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tot++; fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    report();
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    latency(1);
    latency(0);
    pair(0, 0, 0);
    pair(5, 0, 0);
    pair(-5, 0, 0);
    pair(1, 0, 0);
    pair(130, 0, 0);
    pair(-130, 0, 0);
    pair(3, 1, 3);
    pair(-2, 1, 3);
    pair(0, 1, 0);
    pair(4, 1, 3);
    pair(-9, 1, 3);
    pair(20, 1, 0);
    for (int i = 0; i < LOCK_COUNT + 2; i++) pair((i % 2) ? 1 : -2, 0, 2);
    pair(5, 0, 2);
    pair(0, 0, 2);
    for (int i = 0; i < 40; i++)
      pair(int'($urandom_range(24)) - 12, 1'($urandom_range(1)), int'($urandom_range(5)));
    freq_run(6, 10, 1);
    freq_run(10, 6, 0);
    pair(-3, 0, 1);
    report();
  end
endmodule